// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is the purely combinational integer execution unit of a small load/store RISC core. Each cycle it receives two 32-bit register operands, the 16-bit immediate field and the 5-bit shift-amount field of the current instruction, together with the instruction's 6-bit opcode and 6-bit function code. It returns a 32-bit result, a signed-overflow flag and an illegal-operation flag in the same cycle.

When the opcode is zero, the function code chooses a register-register operation: add, subtract, their non-trapping variants, signed set-less-than, the four bitwise operations and six shifts. Any other opcode selects an immediate form. The unit extends the immediate as that form requires: sign extension for arithmetic and compare, zero extension for the bitwise forms, and placement in the upper half for load-upper. Overflow appears only as a flag. Multiply, divide, memory access and branch resolution belong to other units.

Top module: `fc_alu`

## Requirements
- R1: With opcode 0, function codes 32 (add), 33 (add, no trap), 34 (subtract `opa - opb`) and 35 (subtract, no trap) give the two's-complement result modulo 2^32.
- R2: With opcode 0, function codes 36, 37, 38 and 39 give the bitwise AND, OR, XOR and NOR of `opa` and `opb`.
- R3: Set-less-than gives 1 if `opa` is less than the second operand as signed values and 0 otherwise. The second operand is `opb` for opcode 0 with function 42, and the sign-extended immediate for opcode 10.
- R4: With opcode 0, function codes 0, 2 and 3 shift `opa` left logically, right logically and right arithmetically by `shamt`.
- R5: With opcode 0, function codes 4, 6 and 7 shift `opa` left logically, right logically and right arithmetically by `opb[4:0]`. The upper bits of `opb` have no effect.
- R6: Opcodes 8 and 9 add `opa` and the sign-extended immediate.
- R7: Opcodes 12, 13 and 14 give the AND, OR and XOR of `opa` and the zero-extended immediate.
- R8: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0.
- R9: `ovf` is 1 for function 32, function 34 and opcode 8 exactly when the operands of the effective addition share a sign and the result has the other sign.
- R10: `ovf` is 0 for functions 33 and 35, for opcode 9 and for every other operation.
- R11: An undefined function code under opcode 0, or any opcode other than 0, 8, 9, 10, 12, 13, 14 and 15, gives result 0, `illegal` 1 and `ovf` 0. Every defined operation gives `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First register operand; the value that is shifted |
| opb | input | 32 | Second register operand; low 5 bits give the variable shift amount |
| imm | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Constant shift-amount field |
| opcode | input | 6 | Instruction opcode; 0 selects a register-register form |
| funct | input | 6 | Function code, used only when opcode is 0 |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of a trapping add or subtract |
| illegal | output | 1 | Opcode or function code is undefined |

## Verification
Random operand pairs are run against every defined code. This separates the operations from one another and compares the shift paths at all 32 amounts. Directed pairs sit at the signed limits (0x7fffffff plus 1, 0x80000000 minus 1, equal signs that do not overflow). These separate the trapping adds and subtracts from the non-trapping ones and show whether the overflow rule follows the effective sign of the subtrahend. Immediates with bit 15 set distinguish sign, zero and upper placement across the immediate forms. Set-less-than is tried with operands of opposite sign whose wrapped difference has the misleading sign. Random opcodes and function codes reach the undefined space.

// File: rtl/fc_alu_pkg.sv
package fc_alu_pkg;

  localparam int CODE_W = 6;

  // opcodes
  localparam logic [CODE_W-1:0] OPC_REG   = 6'd0;
  localparam logic [CODE_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [CODE_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [CODE_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [CODE_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [CODE_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [CODE_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [CODE_W-1:0] OPC_LUI   = 6'd15;

  // function codes
  localparam logic [CODE_W-1:0] FN_SHL_C = 6'd0;
  localparam logic [CODE_W-1:0] FN_SHR_C = 6'd2;
  localparam logic [CODE_W-1:0] FN_SHA_C = 6'd3;
  localparam logic [CODE_W-1:0] FN_SHL_V = 6'd4;
  localparam logic [CODE_W-1:0] FN_SHR_V = 6'd6;
  localparam logic [CODE_W-1:0] FN_SHA_V = 6'd7;
  localparam logic [CODE_W-1:0] FN_ADD   = 6'd32;
  localparam logic [CODE_W-1:0] FN_ADDU  = 6'd33;
  localparam logic [CODE_W-1:0] FN_SUB   = 6'd34;
  localparam logic [CODE_W-1:0] FN_SUBU  = 6'd35;
  localparam logic [CODE_W-1:0] FN_AND   = 6'd36;
  localparam logic [CODE_W-1:0] FN_OR    = 6'd37;
  localparam logic [CODE_W-1:0] FN_XOR   = 6'd38;
  localparam logic [CODE_W-1:0] FN_NOR   = 6'd39;
  localparam logic [CODE_W-1:0] FN_SLT   = 6'd42;

  typedef enum logic [3:0] {
    K_ARITH, K_LESS, K_AND, K_OR, K_XOR, K_NOR,
    K_SHL, K_SHR, K_SHA, K_PASS, K_ZERO
  } kind_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_HIGH
  } bsrc_e;

  typedef struct packed {
    kind_e kind;
    bsrc_e bsrc;
    logic  negate_b;   // effective addition uses ~b + 1
    logic  amt_reg;    // shift amount taken from opb
    logic  trap_ovf;   // overflow reported for this operation
    logic  bad_code;
  } ctrl_t;

  // Signed overflow of an addition from the three sign bits.
  function automatic logic sum_overflow(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Signed less-than from operand signs and the sign of a - b.
  function automatic logic signed_below(input logic sa, input logic sb, input logic sdiff);
    return (sa != sb) ? sa : sdiff;
  endfunction

endpackage

// File: rtl/fc_alu_decode.sv
module fc_alu_decode
  import fc_alu_pkg::*;
(
  input  logic [CODE_W-1:0] opcode,
  input  logic [CODE_W-1:0] funct,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '{kind: K_ZERO, bsrc: SRC_REG, negate_b: 1'b0,
             amt_reg: 1'b0, trap_ovf: 1'b0, bad_code: 1'b0};
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_ADD:   begin ctrl.kind = K_ARITH; ctrl.trap_ovf = 1'b1; end
          FN_ADDU:  ctrl.kind = K_ARITH;
          FN_SUB:   begin ctrl.kind = K_ARITH; ctrl.negate_b = 1'b1; ctrl.trap_ovf = 1'b1; end
          FN_SUBU:  begin ctrl.kind = K_ARITH; ctrl.negate_b = 1'b1; end
          FN_SLT:   begin ctrl.kind = K_LESS;  ctrl.negate_b = 1'b1; end
          FN_AND:   ctrl.kind = K_AND;
          FN_OR:    ctrl.kind = K_OR;
          FN_XOR:   ctrl.kind = K_XOR;
          FN_NOR:   ctrl.kind = K_NOR;
          FN_SHL_C: ctrl.kind = K_SHL;
          FN_SHR_C: ctrl.kind = K_SHR;
          FN_SHA_C: ctrl.kind = K_SHA;
          FN_SHL_V: begin ctrl.kind = K_SHL; ctrl.amt_reg = 1'b1; end
          FN_SHR_V: begin ctrl.kind = K_SHR; ctrl.amt_reg = 1'b1; end
          FN_SHA_V: begin ctrl.kind = K_SHA; ctrl.amt_reg = 1'b1; end
          default:  ctrl.bad_code = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctrl.kind = K_ARITH; ctrl.bsrc = SRC_SEXT; ctrl.trap_ovf = 1'b1; end
      OPC_ADDIU: begin ctrl.kind = K_ARITH; ctrl.bsrc = SRC_SEXT; end
      OPC_SLTI:  begin ctrl.kind = K_LESS;  ctrl.bsrc = SRC_SEXT; ctrl.negate_b = 1'b1; end
      OPC_ANDI:  begin ctrl.kind = K_AND;   ctrl.bsrc = SRC_ZEXT; end
      OPC_ORI:   begin ctrl.kind = K_OR;    ctrl.bsrc = SRC_ZEXT; end
      OPC_XORI:  begin ctrl.kind = K_XOR;   ctrl.bsrc = SRC_ZEXT; end
      OPC_LUI:   begin ctrl.kind = K_PASS;  ctrl.bsrc = SRC_HIGH; end
      default:   ctrl.bad_code = 1'b1;
    endcase
  end

endmodule

// File: rtl/fc_alu_operand.sv
module fc_alu_operand
  import fc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  bsrc_e             bsrc,
  output logic [DATA_W-1:0] b_sel
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;
  logic [DATA_W-1:0] imm_high;

  assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zext = {{PAD_W{1'b0}}, imm};
  assign imm_high = {imm, {PAD_W{1'b0}}};

  always_comb begin
    unique case (bsrc)
      SRC_SEXT: b_sel = imm_sext;
      SRC_ZEXT: b_sel = imm_zext;
      SRC_HIGH: b_sel = imm_high;
      default:  b_sel = opb;
    endcase
  end

endmodule

// File: rtl/fc_alu_shift.sv
module fc_alu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              to_left,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] out_rev;
  logic              fill;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar j = 0; j < DATA_W; j++) begin : g_rev
    assign din_rev[j] = din[DATA_W-1-j];
    assign out_rev[j] = stage[SH_W][DATA_W-1-j];
  end

  assign fill     = arith & ~to_left & din[DATA_W-1];
  assign stage[0] = to_left ? din_rev : din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int DIST = 1 << i;
    assign stage[i+1] = amt[i] ? {{DIST{fill}}, stage[i][DATA_W-1:DIST]} : stage[i];
  end

  assign dout = to_left ? out_rev : stage[SH_W];

endmodule

// File: rtl/fc_alu.sv
module fc_alu
  import fc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  input  logic [CODE_W-1:0] opcode,
  input  logic [CODE_W-1:0] funct,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              illegal
);

  localparam int MSB = DATA_W - 1;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum_w;
  logic              add_ovf_w;
  logic              lt_w;
  logic [SH_W-1:0]   amt_w;
  logic [DATA_W-1:0] shift_w;

  fc_alu_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  fc_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .opb   (opb),
    .imm   (imm),
    .bsrc  (ctrl.bsrc),
    .b_sel (b_sel)
  );

  // Shared adder: subtraction and compare add the inverted operand plus one.
  assign b_eff     = ctrl.negate_b ? ~b_sel : b_sel;
  assign sum_w     = opa + b_eff + {{(DATA_W-1){1'b0}}, ctrl.negate_b};
  assign add_ovf_w = sum_overflow(opa[MSB], b_eff[MSB], sum_w[MSB]);
  assign lt_w      = signed_below(opa[MSB], b_sel[MSB], sum_w[MSB]);

  assign amt_w = ctrl.amt_reg ? opb[SH_W-1:0] : shamt;

  fc_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .din     (opa),
    .amt     (amt_w),
    .to_left (ctrl.kind == K_SHL),
    .arith   (ctrl.kind == K_SHA),
    .dout    (shift_w)
  );

  always_comb begin
    unique case (ctrl.kind)
      K_ARITH: result = sum_w;
      K_LESS:  result = {{(DATA_W-1){1'b0}}, lt_w};
      K_AND:   result = opa & b_sel;
      K_OR:    result = opa | b_sel;
      K_XOR:   result = opa ^ b_sel;
      K_NOR:   result = ~(opa | b_sel);
      K_SHL,
      K_SHR,
      K_SHA:   result = shift_w;
      K_PASS:  result = b_sel;
      default: result = '0;
    endcase
  end

  assign ovf     = ctrl.trap_ovf & add_ovf_w;
  assign illegal = ctrl.bad_code;

endmodule

// File: rtl/fc_alu_checker.sv
module fc_alu_checker
  import fc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [IMM_W-1:0]  imm,
  input logic [CODE_W-1:0] opcode,
  input logic [CODE_W-1:0] funct,
  input logic [DATA_W-1:0] result,
  input logic              ovf,
  input logic              illegal,
  input logic              add_ovf_w
);

  logic is_reg;
  assign is_reg = (opcode == OPC_REG);

  always_comb begin
    if (illegal)
      assert_illegal_zero_R11: assert (result == '0 && !ovf);
    if (opcode == OPC_ADDIU || (is_reg && (funct == FN_ADDU || funct == FN_SUBU)))
      assert_no_overflow_R10: assert (!ovf);
    if ((opcode == OPC_SLTI || (is_reg && funct == FN_SLT)) && !illegal)
      assert_less_is_bit_R3: assert (result[DATA_W-1:1] == '0);
    if (opcode == OPC_LUI)
      assert_upper_place_R8: assert (result == {imm, {(DATA_W-IMM_W){1'b0}}});
    if (opcode == OPC_ANDI)
      assert_zero_extend_R7: assert (result[DATA_W-1:IMM_W] == '0);
    if (ovf)
      assert_ovf_from_adder_R9: assert (add_ovf_w && !illegal);
  end

endmodule

bind fc_alu fc_alu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .imm       (imm),
  .opcode    (opcode),
  .funct     (funct),
  .result    (result),
  .ovf       (ovf),
  .illegal   (illegal),
  .add_ovf_w (add_ovf_w)
);

// File: tb/fc_alu_test.sv
module fc_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa, opb, result;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [5:0]  opcode, funct;
  logic        ovf, illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fc_alu uut (
    .opa(opa), .opb(opb), .imm(imm), .shamt(shamt),
    .opcode(opcode), .funct(funct),
    .result(result), .ovf(ovf), .illegal(illegal)
  );

  // Reference model written from the requirements.
  function automatic void model(input logic [5:0] oc, input logic [5:0] fn,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh,
                                output logic [31:0] r, output logic o, output logic il);
    longint wide;
    logic [31:0] se, ze;
    se = {{16{im[15]}}, im};
    ze = {16'h0000, im};
    r = 32'h0; o = 1'b0; il = 1'b0;
    case (oc)
      6'd0: case (fn)
        6'd32: begin wide = longint'($signed(a)) + longint'($signed(b)); r = a + b;
                 o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'd33: r = a + b;
        6'd34: begin wide = longint'($signed(a)) - longint'($signed(b)); r = a - b;
                 o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'd35: r = a - b;
        6'd36: r = a & b;
        6'd37: r = a | b;
        6'd38: r = a ^ b;
        6'd39: r = ~(a | b);
        6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'd0:  r = a << sh;
        6'd2:  r = a >> sh;
        6'd3:  r = $unsigned($signed(a) >>> sh);
        6'd4:  r = a << b[4:0];
        6'd6:  r = a >> b[4:0];
        6'd7:  r = $unsigned($signed(a) >>> b[4:0]);
        default: il = 1'b1;
      endcase
      6'd8: begin wide = longint'($signed(a)) + longint'($signed(se)); r = a + se;
              o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      6'd9:  r = a + se;
      6'd10: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'd12: r = a & ze;
      6'd13: r = a | ze;
      6'd14: r = a ^ ze;
      6'd15: r = {im, 16'h0000};
      default: il = 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] oc, input logic [5:0] fn);
    if (oc == 6'd0) begin
      case (fn)
        6'd32, 6'd33, 6'd34, 6'd35: return "R1";
        6'd36, 6'd37, 6'd38, 6'd39: return "R2";
        6'd42: return "R3";
        6'd0, 6'd2, 6'd3: return "R4";
        6'd4, 6'd6, 6'd7: return "R5";
        default: return "R11";
      endcase
    end
    case (oc)
      6'd8, 6'd9: return "R6";
      6'd10: return "R3";
      6'd12, 6'd13, 6'd14: return "R7";
      6'd15: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [5:0] oc, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input string tag);
    logic [31:0] er;
    logic eo, ei;
    @(negedge clk);
    opcode = oc; funct = fn; opa = a; opb = b; imm = im; shamt = sh;
    #2;
    model(oc, fn, a, b, im, sh, er, eo, ei);
    checks++;
    if (result !== er || ovf !== eo || illegal !== ei) begin
      errors++;
      $display("FAIL %s op=%0d fn=%0d a=%h b=%h imm=%h sh=%0d: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
               tag, oc, fn, a, b, im, sh, result, ovf, illegal, er, eo, ei);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] legal_fn [15];
    logic [5:0] legal_oc [7];
    void'($urandom(32'd4242));
    legal_fn = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39,
                 6'd42, 6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7};
    legal_oc = '{6'd8, 6'd9, 6'd10, 6'd12, 6'd13, 6'd14, 6'd15};
    opa = '0; opb = '0; imm = '0; shamt = '0; opcode = '0; funct = 6'd32;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // quiet state: add of zeros
    apply(6'd0, 6'd32, 32'h0, 32'h0, 16'h0, 5'd0, "R1");
    // R9: positive overflow on add, and on subtract of a negative
    apply(6'd0, 6'd32, 32'h7fffffff, 32'h1, 16'h0, 5'd0, "R9");
    apply(6'd0, 6'd34, 32'h80000000, 32'h1, 16'h0, 5'd0, "R9");
    apply(6'd0, 6'd34, 32'h7fffffff, 32'hffffffff, 16'h0, 5'd0, "R9");
    apply(6'd0, 6'd34, 32'hffffffff, 32'hffffffff, 16'h0, 5'd0, "R9");
    apply(6'd8, 6'd0, 32'h7ffffff0, 32'h0, 16'h0010, 5'd0, "R9");
    // R10: same operands, non-trapping forms
    apply(6'd0, 6'd33, 32'h7fffffff, 32'h1, 16'h0, 5'd0, "R10");
    apply(6'd0, 6'd35, 32'h80000000, 32'h1, 16'h0, 5'd0, "R10");
    apply(6'd9, 6'd0, 32'h7ffffff0, 32'h0, 16'h0010, 5'd0, "R10");
    // R3: opposite signs where the wrapped difference misleads
    apply(6'd0, 6'd42, 32'h80000000, 32'h7fffffff, 16'h0, 5'd0, "R3");
    apply(6'd0, 6'd42, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0, "R3");
    apply(6'd10, 6'd0, 32'hfffffffe, 32'h0, 16'hffff, 5'd0, "R3");
    // R6/R7/R8: immediate with bit 15 set
    apply(6'd8, 6'd0, 32'h00000010, 32'h0, 16'hfff0, 5'd0, "R6");
    apply(6'd13, 6'd0, 32'h00000000, 32'h0, 16'h8001, 5'd0, "R7");
    apply(6'd15, 6'd0, 32'hdeadbeef, 32'h0, 16'h8421, 5'd0, "R8");
    // R4/R5: arithmetic fill and upper opb bits ignored
    apply(6'd0, 6'd3, 32'h80000000, 32'h0, 16'h0, 5'd31, "R4");
    apply(6'd0, 6'd7, 32'h80000000, 32'hffffffe4, 16'h0, 5'd0, "R5");
    apply(6'd0, 6'd4, 32'h00000001, 32'h12345661, 16'h0, 5'd0, "R5");
    // R11: undefined codes
    apply(6'd0, 6'd1, 32'hffffffff, 32'hffffffff, 16'hffff, 5'd3, "R11");
    apply(6'd0, 6'd63, 32'h7fffffff, 32'h1, 16'h0, 5'd0, "R11");
    apply(6'd11, 6'd32, 32'h12345678, 32'h1, 16'h1234, 5'd0, "R11");

    for (int n = 0; n < 4000; n++) begin
      logic [5:0] oc, fn;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 6) begin
        oc = 6'd0; fn = legal_fn[$urandom_range(0, 14)];
      end else if (pick < 9) begin
        oc = legal_oc[$urandom_range(0, 6)]; fn = 6'($urandom());
      end else begin
        oc = 6'($urandom()); fn = 6'($urandom());
      end
      apply(oc, fn, $urandom(), $urandom(), 16'($urandom()), 5'($urandom()), tag_of(oc, fn));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule